// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block watches the write cycles a host issues toward a parallel NOR flash that uses the classic two-cycle unlock command protocol. It tracks where the host is in an unlock and command sequence and reports the resulting device mode. It also drives program and erase strobes into a small on-block byte array that stands in for the flash cells. Programming can only clear bits. Sector and chip erases return bytes to 0xFF and hold the device busy for a set number of clock cycles. An unlock-bypass mode lets a host issue program commands without repeating the unlock pair each time.

The write port is a plain strobe and has no back-pressure. Every cycle with `wr_en` high is one bus write, and the block consumes it in that cycle. Writes that arrive while an erase is running are dropped by design and are never stalled. The read port is a combinational view of the byte array. It lets the host or a bench see the effect of program and erase.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, mode is 0 (array read), bypass is 0, busy is 0 and every array byte reads 0xFF.
- R2: Command address compares use the word address, which is the byte address shifted right by 1 when BUS_BYTES is 2 and by 2 when BUS_BYTES is 4. A byte address equal to an unscaled command address does not match.
- R3: A write of 0xAA to word 0x555, then a write of 0x55 to word 0x2AA, reaches the command cycle. Any other value or address at either step returns the block to array read.
- R4: In the command cycle, a write to word 0x555 selects the next mode, where mode encodes 0 read, 1 autoselect, 2 program, 3 erase and 4 CFI query. 0x90 selects 1, 0xA0 selects 2 and 0x80 selects 3. 0x20 sets bypass and leaves mode at 0. Any other value returns to read with bypass clear.
- R5: Writing 0xF0 returns to read and clears bypass from every state except the program data cycle, where 0xF0 is taken as data.
- R6: Writing 0x98 to word 0x55 enters CFI mode (4), either from read or from autoselect. The next write of any kind returns the block to read and does not start an unlock.
- R7: The program data cycle replaces the addressed byte with the AND of its old value and the written data. The addressed byte is the low log2(ARR_BYTES) bits of the byte address. No other byte changes.
- R8: After erase setup, a second unlock pair followed by 0x30 at any address erases the sector that holds that byte address, setting every byte in that sector to 0xFF and leaving all other bytes unchanged.
- R9: After erase setup and a second unlock pair, 0x10 at word 0x555 sets every array byte to 0xFF. 0x10 at any other address returns to read and erases nothing.
- R10: Busy is high for exactly SECT_CYC cycles after a sector erase command and for exactly CHIP_CYC cycles after a chip erase command. While busy, every write, 0xF0 included, has no effect on the mode, the bypass flag or the array.
- R11: With bypass set, the command cycle accepts commands at any address. After each program data cycle the block returns to the command cycle with bypass still set. Autoselect followed by 0x00 clears bypass.
- R12: When an erase finishes, the block returns to the command cycle if bypass is set and to array read otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | log2(ARR_BYTES) | Array byte to view |
| rd_data | output | 8 | Array byte at rd_addr |
| mode | output | 3 | Device mode: 0 read, 1 autoselect, 2 program, 3 erase, 4 CFI |
| bypass | output | 1 | Unlock-bypass active |
| prog_pulse | output | 1 | Program data cycle accepted this cycle |
| erase_pulse | output | 1 | Sector or chip erase started this cycle |
| busy | output | 1 | Erase in progress |

## Verification
The following outputs take effect on the clock edge that samples the write: the mode, the bypass flag and the array contents after program or erase. The bench drives each write on a falling edge and checks the outputs at the next falling edge, exactly one rising edge later. Busy rises on the same edge that accepts the erase command. The bench then counts the falling edges on which busy reads high and expects that count to equal SECT_CYC or CHIP_CYC. While busy is high, the bench issues a write on every cycle to show that none of them take effect.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  typedef enum logic [2:0] {
    MODE_READ    = 3'd0,
    MODE_AUTOSEL = 3'd1,
    MODE_PROGRAM = 3'd2,
    MODE_ERASE   = 3'd3,
    MODE_CFI     = 3'd4
  } mode_e;

  typedef enum logic [3:0] {
    S_READ, S_UNLK1, S_CMD, S_PROG, S_AUTO,
    S_EUNLK0, S_EUNLK1, S_ECMD, S_ERASING, S_CFI
  } seq_state_e;

  localparam logic [7:0] K_UNLK_A   = 8'hAA;
  localparam logic [7:0] K_UNLK_B   = 8'h55;
  localparam logic [7:0] K_RESET    = 8'hF0;
  localparam logic [7:0] K_ERSETUP  = 8'h80;
  localparam logic [7:0] K_AUTOSEL  = 8'h90;
  localparam logic [7:0] K_PROGRAM  = 8'hA0;
  localparam logic [7:0] K_BYPASS   = 8'h20;
  localparam logic [7:0] K_CHIPER   = 8'h10;
  localparam logic [7:0] K_SECTER   = 8'h30;
  localparam logic [7:0] K_QUERY    = 8'h98;
  localparam logic [7:0] K_BYP_EXIT = 8'h00;
endpackage

// File: rtl/nfc_addr_dec.sv
module nfc_addr_dec #(
  parameter int ADDR_W    = 16,
  parameter int BUS_BYTES = 2
) (
  input  logic [ADDR_W-1:0] byte_addr,
  output logic              hit_555,
  output logic              hit_2aa,
  output logic              hit_055
);
  localparam int SHIFT = (BUS_BYTES == 4) ? 2 : (BUS_BYTES == 2) ? 1 : 0;

  logic [ADDR_W-1:0] word_addr;

  generate
    if (SHIFT == 0) begin : g_byte
      assign word_addr = byte_addr;
    end else begin : g_wide
      assign word_addr = {{SHIFT{1'b0}}, byte_addr[ADDR_W-1:SHIFT]};
    end
  endgenerate

  assign hit_555 = (word_addr == ADDR_W'(12'h555));
  assign hit_2aa = (word_addr == ADDR_W'(12'h2AA));
  assign hit_055 = (word_addr == ADDR_W'(12'h055));
endmodule

// File: rtl/nfc_erase_timer.sv
module nfc_erase_timer #(
  parameter int SECT_CYC = 20,
  parameter int CHIP_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_sect,
  input  logic start_chip,
  output logic done
);
  localparam int MAX_CYC = (CHIP_CYC > SECT_CYC) ? CHIP_CYC : SECT_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start_chip) cnt <= CNT_W'(CHIP_CYC);
    else if (start_sect) cnt <= CNT_W'(SECT_CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == CNT_W'(1));

  p_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !start_sect && !start_chip) |=> (cnt == $past(cnt) - 1'b1));
  p_start_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_sect || start_chip) |-> (cnt == '0));
endmodule

// File: rtl/nfc_seq_fsm.sv
module nfc_seq_fsm
  import nfc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       hit_555,
  input  logic       hit_2aa,
  input  logic       hit_055,
  input  logic       erase_done,
  output logic [2:0] mode,
  output logic       bypass,
  output logic       busy,
  output logic       prog_en,
  output logic       er_sect,
  output logic       er_chip
);
  seq_state_e st, st_nx;
  logic       byp_nx;

  always_comb begin
    st_nx   = st;
    byp_nx  = bypass;
    prog_en = 1'b0;
    er_sect = 1'b0;
    er_chip = 1'b0;
    if (st == S_ERASING) begin
      if (erase_done) st_nx = bypass ? S_CMD : S_READ;
    end else if (wr_en) begin
      if (wr_data == K_RESET && st != S_PROG) begin
        st_nx  = S_READ;
        byp_nx = 1'b0;
      end else begin
        st_nx  = S_READ;
        byp_nx = 1'b0;
        unique case (st)
          S_READ: begin
            if (hit_055 && wr_data == K_QUERY)       st_nx = S_CFI;
            else if (hit_555 && wr_data == K_UNLK_A) st_nx = S_UNLK1;
          end
          S_UNLK1: begin
            if (hit_2aa && wr_data == K_UNLK_B) st_nx = S_CMD;
          end
          S_CMD: begin
            if (bypass || hit_555) begin
              byp_nx = bypass;
              unique case (wr_data)
                K_BYPASS:  begin st_nx = S_CMD; byp_nx = 1'b1; end
                K_ERSETUP: st_nx = S_EUNLK0;
                K_AUTOSEL: st_nx = S_AUTO;
                K_PROGRAM: st_nx = S_PROG;
                default:   byp_nx = 1'b0;
              endcase
            end
          end
          S_PROG: begin
            prog_en = 1'b1;
            byp_nx  = bypass;
            st_nx   = bypass ? S_CMD : S_READ;
          end
          S_AUTO: begin
            if (!(bypass && wr_data == K_BYP_EXIT) && hit_055 && wr_data == K_QUERY)
              st_nx = S_CFI;
          end
          S_EUNLK0: begin
            if (hit_555 && wr_data == K_UNLK_A) begin st_nx = S_EUNLK1; byp_nx = bypass; end
          end
          S_EUNLK1: begin
            if (hit_2aa && wr_data == K_UNLK_B) begin st_nx = S_ECMD; byp_nx = bypass; end
          end
          S_ECMD: begin
            if (wr_data == K_SECTER) begin
              st_nx = S_ERASING; byp_nx = bypass; er_sect = 1'b1;
            end else if (wr_data == K_CHIPER && hit_555) begin
              st_nx = S_ERASING; byp_nx = bypass; er_chip = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_READ;
      bypass <= 1'b0;
    end else begin
      st     <= st_nx;
      bypass <= byp_nx;
    end
  end

  always_comb begin
    unique case (st)
      S_PROG:                                mode = MODE_PROGRAM;
      S_AUTO:                                mode = MODE_AUTOSEL;
      S_EUNLK0, S_EUNLK1, S_ECMD, S_ERASING: mode = MODE_ERASE;
      S_CFI:                                 mode = MODE_CFI;
      default:                               mode = MODE_READ;
    endcase
  end

  assign busy = (st == S_ERASING);

  p_unlock_fail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_UNLK1 && wr_en && !(hit_2aa && wr_data == K_UNLK_B)) |=> (st == S_READ && !bypass));
  p_f0_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == K_RESET && st != S_PROG && st != S_ERASING) |=> (mode == MODE_READ && !bypass));
  p_cfi_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CFI && wr_en) |=> (st == S_READ));
  p_busy_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!prog_en && !er_sect && !er_chip && $stable(bypass)));
  p_bypass_prog_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && bypass) |=> (st == S_CMD && bypass));
  p_erase_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && erase_done) |=> (st == ($past(bypass) ? S_CMD : S_READ)));
endmodule

// File: rtl/nfc_cell_array.sv
module nfc_cell_array #(
  parameter int ARR_BYTES  = 64,
  parameter int SECT_BYTES = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         prog_en,
  input  logic                         er_sect,
  input  logic                         er_chip,
  input  logic [$clog2(ARR_BYTES)-1:0] wr_idx,
  input  logic [7:0]                   wr_data,
  input  logic [$clog2(ARR_BYTES)-1:0] rd_idx,
  output logic [7:0]                   rd_data
);
  localparam int IDX_W   = $clog2(ARR_BYTES);
  localparam int SECT_SH = $clog2(SECT_BYTES);

  logic [7:0]       mem [ARR_BYTES];
  logic [IDX_W-1:0] sect_base;

  assign sect_base = (wr_idx >> SECT_SH) << SECT_SH;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ARR_BYTES; i++) mem[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < ARR_BYTES; i++) begin
        if (er_chip || (er_sect && (IDX_W'(i) >> SECT_SH) == (sect_base >> SECT_SH)))
          mem[i] <= 8'hFF;
        else if (prog_en && wr_idx == IDX_W'(i))
          mem[i] <= mem[i] & wr_data;
      end
    end
  end

  assign rd_data = mem[rd_idx];

  generate
    for (genvar g = 0; g < ARR_BYTES; g++) begin : g_chk
      p_and_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en && wr_idx == IDX_W'(g)) |=> (mem[g] == ($past(mem[g]) & $past(wr_data))));
      p_erase_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (er_sect && (wr_idx >> SECT_SH) == (IDX_W'(g) >> SECT_SH)) |=> (mem[g] == 8'hFF));
    end
  endgenerate
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
  parameter int ADDR_W     = 16,
  parameter int BUS_BYTES  = 2,
  parameter int ARR_BYTES  = 64,
  parameter int SECT_BYTES = 16,
  parameter int SECT_CYC   = 20,
  parameter int CHIP_CYC   = 200,
  localparam int IDX_W     = $clog2(ARR_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [7:0]        rd_data,
  output logic [2:0]        mode,
  output logic              bypass,
  output logic              prog_pulse,
  output logic              erase_pulse,
  output logic              busy
);
  logic hit_555, hit_2aa, hit_055, erase_done, er_sect, er_chip;

  nfc_addr_dec #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_dec (
    .byte_addr(wr_addr), .hit_555(hit_555), .hit_2aa(hit_2aa), .hit_055(hit_055)
  );

  nfc_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .hit_555(hit_555), .hit_2aa(hit_2aa), .hit_055(hit_055),
    .erase_done(erase_done), .mode(mode), .bypass(bypass), .busy(busy),
    .prog_en(prog_pulse), .er_sect(er_sect), .er_chip(er_chip)
  );

  nfc_erase_timer #(.SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start_sect(er_sect), .start_chip(er_chip), .done(erase_done)
  );

  nfc_cell_array #(.ARR_BYTES(ARR_BYTES), .SECT_BYTES(SECT_BYTES)) u_arr (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_pulse), .er_sect(er_sect), .er_chip(er_chip),
    .wr_idx(wr_addr[IDX_W-1:0]), .wr_data(wr_data), .rd_idx(rd_addr), .rd_data(rd_data)
  );

  assign erase_pulse = er_sect | er_chip;

  p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_pulse && erase_pulse));
  p_erase_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    erase_pulse |=> busy);
endmodule

// File: tb/tb_nor_cmd_seq.sv
module tb_nor_cmd_seq;
  localparam int SECT_CYC = 20;
  localparam int CHIP_CYC = 200;
  localparam logic [15:0] A555 = 16'h0AAA;
  localparam logic [15:0] A2AA = 16'h0554;
  localparam logic [15:0] A055 = 16'h00AA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [5:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [2:0] mode;
  logic bypass, prog_pulse, erase_pulse, busy;

  int n_chk = 0, n_bad = 0;
  logic [7:0] refm [64];

  always #10 clk = ~clk;

  nor_cmd_seq #(.ADDR_W(16), .BUS_BYTES(2), .ARR_BYTES(64), .SECT_BYTES(16),
                .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .mode(mode), .bypass(bypass),
    .prog_pulse(prog_pulse), .erase_pulse(erase_pulse), .busy(busy)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(A555, 8'hAA);
    wr(A2AA, 8'h55);
  endtask

  task automatic chk_array(string tag);
    for (int i = 0; i < 64; i++) begin
      rd_addr = 6'(i);
      #1;
      chk(tag, rd_data, refm[i]);
    end
  endtask

  task automatic count_busy(string tag, int exp);
    int c = 0;
    while (busy && c < 1000) begin
      c++;
      wr_en = 1'b1; wr_addr = (c % 2) ? A555 : 16'h0003;
      wr_data = (c % 3 == 0) ? 8'hF0 : (c % 3 == 1) ? 8'h00 : 8'hAA;
      @(negedge clk);
      if (busy) chk({tag, " mode while busy"}, mode, 3);
    end
    wr_en = 1'b0;
    chk(tag, c, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) refm[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 mode", mode, 0); chk("R1 bypass", bypass, 0); chk("R1 busy", busy, 0);
    chk_array("R1 array");

    // R2 scaled vs unscaled command addresses
    unlock(); wr(A555, 8'h90); chk("R2 scaled autoselect", mode, 1);
    wr(16'h0000, 8'hF0);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h90);
    chk("R2 unscaled ignored", mode, 0);

    // R3 bad data / bad address at each unlock step
    wr(A555, 8'hAA); wr(A2AA, 8'h56); wr(A555, 8'h90); chk("R3 bad data", mode, 0);
    wr(A555, 8'hAA); wr(A555, 8'h55); wr(A555, 8'h90); chk("R3 bad addr", mode, 0);
    wr(A2AA, 8'hAA); wr(A2AA, 8'h55); wr(A555, 8'h90); chk("R3 bad first", mode, 0);

    // R4 sweep of every command byte
    for (int v = 0; v < 256; v++) begin
      int em;
      unlock(); wr(A555, 8'(v));
      em = (v == 8'h90) ? 1 : (v == 8'hA0) ? 2 : (v == 8'h80) ? 3 : 0;
      chk($sformatf("R4 mode for %0h", v), mode, em);
      chk($sformatf("R4 bypass for %0h", v), bypass, (v == 8'h20) ? 1 : 0);
      if (v == 8'hA0) wr(16'h003F, 8'hFF); else wr(16'h0000, 8'hF0);
      chk("R5 F0 / cleanup mode", mode, 0); chk("R5 F0 clears bypass", bypass, 0);
    end
    unlock(); wr(A2AA, 8'h90); chk("R4 wrong command address", mode, 0);

    // R5 F0 taken as program data
    unlock(); wr(A555, 8'hA0); wr(16'h0005, 8'hF0); refm[5] = refm[5] & 8'hF0;
    rd_addr = 6'd5; #1; chk("R5 F0 as data", rd_data, 8'hF0); chk("R5 mode", mode, 0);

    // R6 CFI entry from read and from autoselect, exit on any write
    wr(A055, 8'h98); chk("R6 cfi from read", mode, 4);
    wr(16'h1234, 8'h12); chk("R6 cfi exit", mode, 0);
    unlock(); wr(A555, 8'h90); wr(A055, 8'h98); chk("R6 cfi from autosel", mode, 4);
    wr(A555, 8'hAA); wr(A2AA, 8'h55); wr(A555, 8'h90); chk("R6 exit no unlock", mode, 0);

    // R7 AND-only programming over every byte, two passes
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 64; i++) begin
        logic [7:0] d = 8'((i * 37 + p * 91 + 11) ^ (p ? 8'h3C : 8'hC3));
        unlock(); wr(A555, 8'hA0); wr(16'h4000 | 16'(i), d);
        refm[i] = refm[i] & d;
      end
    chk_array("R7 array after programming");

    // R8 sector erase of sector 1, busy window with writes ignored (R10)
    unlock(); wr(A555, 8'h80); unlock(); wr(16'h0017, 8'h30);
    chk("R8 busy", busy, 1);
    for (int i = 16; i < 32; i++) refm[i] = 8'hFF;
    count_busy("R10 sector busy cycles", SECT_CYC);
    chk("R12 back to read", mode, 0); chk("R10 bypass kept", bypass, 0);
    chk_array("R8 sector filled, others kept");

    // R9 chip erase with wrong address does nothing
    unlock(); wr(A555, 8'h80); unlock(); wr(A2AA, 8'h10);
    chk("R9 bad addr mode", mode, 0); chk("R9 bad addr busy", busy, 0);
    chk_array("R9 nothing erased");
    unlock(); wr(A555, 8'h80); unlock(); wr(A555, 8'h10);
    for (int i = 0; i < 64; i++) refm[i] = 8'hFF;
    count_busy("R10 chip busy cycles", CHIP_CYC);
    chk_array("R9 chip filled");

    // R11 bypass mode
    unlock(); wr(A555, 8'h20); chk("R11 bypass set", bypass, 1); chk("R11 mode", mode, 0);
    wr(16'h1234, 8'hA0); chk("R11 program no unlock", mode, 2);
    wr(16'h0009, 8'h3C); refm[9] = 8'h3C;
    chk("R11 back to cmd", mode, 0); chk("R11 bypass held", bypass, 1);
    wr(16'h7770, 8'h80); chk("R11 erase setup any addr", mode, 3);
    unlock(); wr(16'h0025, 8'h30);
    count_busy("R10 bypass sector busy", SECT_CYC);
    chk("R12 bypass after erase", bypass, 1);
    wr(16'h0101, 8'hA0); chk("R12 command cycle after erase", mode, 2);
    wr(16'h0026, 8'h0F); refm[38] = 8'h0F;
    wr(16'h0202, 8'h90); chk("R11 autoselect", mode, 1);
    wr(16'h0202, 8'h00); chk("R11 exit mode", mode, 0); chk("R11 exit bypass", bypass, 0);
    wr(16'h1234, 8'hA0); chk("R11 no program after exit", mode, 0);
    chk_array("R11 array");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule